// File: doc/BRIEF.md
# SPI Burst Transfer Engine

A register-mapped SPI master that carries out one full-duplex burst of up to 64 bytes at a time. Software fills a buffer of sixteen 32-bit words with the bytes to send. It programs the number of bits, clears the done flag and sets the start bit. It then polls the done flag until it reads 1. The engine clocks the buffer out on MOSI and, when capture is enabled, writes the sampled MISO bytes back into the same buffer byte positions. Software reads the received bytes from the buffer when the burst is over.

A hold control keeps chip select asserted after a burst ends. This lets one SPI message be split across several bursts without a gap on chip select. A software reset bit stops a burst at any point and returns the pins to idle. A mode bit holds off all starts while it is set. The serial clock runs in mode 0: SCK idles low, MOSI changes while SCK is low, and MISO is sampled on the rising edge. Each half period of SCK lasts `HALF_DIV` system clocks.

The shifter runs through four states. `ST_IDLE` waits for a start. `ST_LEAD` is the low half of SCK. `ST_TRAIL` is the high half of SCK. `ST_DONE` is the one-cycle wrap-up. The transitions are:
- IDLE→LEAD on an accepted start.
- LEAD→TRAIL when the half period expires.
- TRAIL→LEAD when the half period expires and bits remain.
- TRAIL→DONE when the half period expires on the last bit.
- DONE→IDLE always.
- Any state→IDLE on a software reset.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, the start bit (bit 18 of offset 0x00) reads 0 and the done flag (bit 4 of offset 0x30) reads 0.
- R2: Writing 1 to bit 18 of offset 0x00 while idle starts a burst. In the next cycle, `spi_cs_n` is 0 and bit 18 reads back as 1.
- R3: A burst shifts out (N+1) bits, where N is the value in bits [25:17] of offset 0x20. Bits leave MSB first, starting with buffer byte 0. Buffer byte k is byte k%4 of the word at offset 0x40+4*(k/4), with byte 0 in bits [7:0].
- R4: When bit 0 of offset 0x1C is 1, each received byte overwrites the buffer byte that was sent in the same slot. When that bit is 0, the buffer is left unchanged.
- R5: When a burst ends, the done flag (bit 4 of offset 0x30) becomes 1 and the start bit clears itself. Writing 0 to bit 4 clears the flag.
- R6: When bit 30 of offset 0x2C is 1, chip select stays asserted after the burst ends. When that bit is 0, chip select is released at the end of the burst.
- R7: SCK is low whenever no burst is running. MOSI does not change while SCK is high.
- R8: A start written while a burst is running is ignored. The burst keeps its bit count and its data.
- R9: Writing 1 to bit 31 of offset 0x30 aborts any burst. In the next cycle, chip select is released, SCK is low, the start bit reads 0 and the done flag reads 0.
- R10: While bit 30 of offset 0x30 is 1, a start is ignored: chip select stays released and the start bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 7 | Byte address of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench looks at burst lengths that cut a 32-bit word partway and at the full 64-byte buffer. A byte-lane or endianness slip would put the wrong bytes on MOSI, and a length that is off by one would add or drop one SCK pulse. A two-burst message with hold set must keep chip select low between the bursts. The serial stream must carry on without a restart, and the second buffer must be filled from the stream at its new position. A start written mid-burst and a software reset mid-burst are the other two cases. A design that restarts on the second start would give extra clock pulses. A design that handles the reset badly would leave chip select low or keep SCK toggling after the abort.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
    // control register word indices (byte offset / 4)
    localparam int IDX_CMD    = 0;
    localparam int IDX_DUPLEX = 7;
    localparam int IDX_LEN    = 8;
    localparam int IDX_HOLD   = 11;
    localparam int IDX_CTRL   = 12;

    // field positions
    localparam int START_BIT  = 18;
    localparam int DUPLEX_BIT = 0;
    localparam int LEN_LSB    = 17;
    localparam int HOLD_BIT   = 30;
    localparam int DONE_BIT   = 4;
    localparam int MODE_BIT   = 30;
    localparam int SRST_BIT   = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL,
        ST_DONE
    } shf_state_t;
endpackage

// File: rtl/spi_burst_buffer.sv
module spi_burst_buffer #(
    parameter int WORDS = 16,
    localparam int BYTES = WORDS * 4,
    localparam int BI_W  = $clog2(BYTES),
    localparam int WI_W  = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [WI_W-1:0] bus_widx,
    input  logic [31:0]     bus_wdata,
    input  logic [WI_W-1:0] rd_widx,
    output logic [31:0]     rd_word,
    input  logic [BI_W-1:0] eng_idx,
    input  logic            eng_we,
    input  logic [7:0]      eng_wbyte,
    output logic [7:0]      eng_rbyte
);
    logic [7:0] mem [BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= '0;
        end else begin
            if (bus_we) begin
                for (int b = 0; b < 4; b++) mem[{bus_widx, 2'(b)}] <= bus_wdata[8*b +: 8];
            end
            if (eng_we) mem[eng_idx] <= eng_wbyte;
        end
    end

    // little-endian lane assembly: byte 0 sits in bits [7:0]
    for (genvar b = 0; b < 4; b++) begin : g_lane
        assign rd_word[8*b +: 8] = mem[{rd_widx, 2'(b)}];
    end

    assign eng_rbyte = mem[eng_idx];
endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
    import spi_burst_pkg::*;
#(
    parameter int BYTES    = 64,
    parameter int HALF_DIV = 2,
    localparam int CNT_W = $clog2(BYTES * 8),
    localparam int BI_W  = CNT_W - 3,
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic [CNT_W-1:0] bit_last,
    input  logic             duplex,
    input  logic             hold,
    input  logic             miso,
    input  logic [7:0]       tx_byte,
    output logic [BI_W-1:0]  byte_idx,
    output logic             rx_we,
    output logic [7:0]       rx_byte,
    output logic             busy,
    output logic             finish,
    output logic             sck,
    output logic             mosi,
    output logic             cs_n
);
    shf_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       sh_q;
    logic             sck_q, csn_q;
    logic             half_end, last_bit;

    assign half_end = (div_q == DIV_W'(HALF_DIV - 1));
    assign last_bit = (cnt_q == bit_last);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (half_end) state_d = ST_TRAIL;
            ST_TRAIL: if (half_end) state_d = last_bit ? ST_DONE : ST_LEAD;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state_q <= ST_IDLE;
        else if (abort) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // datapath and pin registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= '0;
            sh_q  <= '0;
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else if (abort) begin
            cnt_q <= '0;
            div_q <= '0;
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    csn_q <= 1'b0;
                    cnt_q <= '0;
                    div_q <= '0;
                    sck_q <= 1'b0;
                end
                ST_LEAD: if (half_end) begin
                    sck_q <= 1'b1;
                    sh_q  <= {sh_q[6:0], miso};
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
                ST_TRAIL: if (half_end) begin
                    sck_q <= 1'b0;
                    div_q <= '0;
                    if (!last_bit) cnt_q <= cnt_q + 1'b1;
                end else begin
                    div_q <= div_q + 1'b1;
                end
                ST_DONE: csn_q <= !hold;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign finish   = (state_q == ST_DONE);
    assign byte_idx = cnt_q[CNT_W-1:3];
    assign rx_byte  = sh_q;
    assign rx_we    = duplex && (state_q == ST_TRAIL) && half_end
                      && ((cnt_q[2:0] == 3'd7) || last_bit);
    assign mosi     = ((state_q == ST_LEAD) || (state_q == ST_TRAIL))
                      && tx_byte[3'd7 - cnt_q[2:0]];
    assign sck      = sck_q;
    assign cs_n     = csn_q;

    a_r7_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sck_q);
    a_r7_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(mosi));
    a_r6_cs_low_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LEAD) || (state_q == ST_TRAIL)) |-> !csn_q);
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int BUF_WORDS = 16,
    parameter int HALF_DIV  = 2,
    localparam int BYTES  = BUF_WORDS * 4,
    localparam int ADDR_W = $clog2(BYTES) + 1,
    localparam int CNT_W  = $clog2(BYTES * 8),
    localparam int BI_W   = CNT_W - 3,
    localparam int WI_W   = $clog2(BUF_WORDS),
    localparam int RI_W   = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic             duplex_q, hold_q, mode_q, done_q;
    logic [CNT_W-1:0] len_q;
    logic             in_buf, soft_rst, start, busy, finish;
    logic [RI_W-1:0]  ridx;
    logic [BI_W-1:0]  eng_idx;
    logic             eng_we;
    logic [7:0]       eng_wbyte, eng_rbyte;
    logic [31:0]      buf_word;

    assign in_buf   = reg_addr[ADDR_W-1];
    assign ridx     = reg_addr[ADDR_W-2:2];
    assign soft_rst = reg_wen && !in_buf && (ridx == RI_W'(IDX_CTRL)) && reg_wdata[SRST_BIT];
    assign start    = reg_wen && !in_buf && (ridx == RI_W'(IDX_CMD)) && reg_wdata[START_BIT]
                      && !busy && !mode_q && !soft_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duplex_q <= 1'b0;
            hold_q   <= 1'b0;
            mode_q   <= 1'b0;
            done_q   <= 1'b0;
            len_q    <= '0;
        end else begin
            if (reg_wen && !in_buf) begin
                unique case (ridx)
                    RI_W'(IDX_DUPLEX): duplex_q <= reg_wdata[DUPLEX_BIT];
                    RI_W'(IDX_LEN):    len_q    <= reg_wdata[LEN_LSB +: CNT_W];
                    RI_W'(IDX_HOLD):   hold_q   <= reg_wdata[HOLD_BIT];
                    RI_W'(IDX_CTRL):   mode_q   <= reg_wdata[MODE_BIT];
                    default: ;
                endcase
            end
            if (soft_rst)
                done_q <= 1'b0;
            else if (finish)
                done_q <= 1'b1;
            else if (reg_wen && !in_buf && (ridx == RI_W'(IDX_CTRL)))
                done_q <= done_q & reg_wdata[DONE_BIT];
        end
    end

    spi_burst_buffer #(.WORDS(BUF_WORDS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (reg_wen && in_buf && !busy),
        .bus_widx  (reg_addr[WI_W+1:2]),
        .bus_wdata (reg_wdata),
        .rd_widx   (reg_addr[WI_W+1:2]),
        .rd_word   (buf_word),
        .eng_idx   (eng_idx),
        .eng_we    (eng_we),
        .eng_wbyte (eng_wbyte),
        .eng_rbyte (eng_rbyte)
    );

    spi_burst_shifter #(.BYTES(BYTES), .HALF_DIV(HALF_DIV)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (soft_rst),
        .start    (start),
        .bit_last (len_q),
        .duplex   (duplex_q),
        .hold     (hold_q),
        .miso     (spi_miso),
        .tx_byte  (eng_rbyte),
        .byte_idx (eng_idx),
        .rx_we    (eng_we),
        .rx_byte  (eng_wbyte),
        .busy     (busy),
        .finish   (finish),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n)
    );

    always_comb begin
        reg_rdata = '0;
        if (in_buf) begin
            reg_rdata = buf_word;
        end else begin
            unique case (ridx)
                RI_W'(IDX_CMD):    reg_rdata[START_BIT]         = busy;
                RI_W'(IDX_DUPLEX): reg_rdata[DUPLEX_BIT]        = duplex_q;
                RI_W'(IDX_LEN):    reg_rdata[LEN_LSB +: CNT_W]  = len_q;
                RI_W'(IDX_HOLD):   reg_rdata[HOLD_BIT]          = hold_q;
                RI_W'(IDX_CTRL): begin
                    reg_rdata[MODE_BIT] = mode_q;
                    reg_rdata[DONE_BIT] = done_q;
                end
                default: ;
            endcase
        end
    end

    a_r9_soft_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && spi_cs_n && !spi_sck && !done_q));
    a_r5_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !soft_rst) |=> (done_q && !busy));
    a_r10_mode_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !busy) |=> !busy);
    a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish && !soft_rst) |=> busy);
endmodule

// File: tb/spi_burst_engine_bench.sv
module spi_burst_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        miso_r = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] tx_b [64];
    logic [7:0] resp_b [64];
    logic [7:0] cap_b [64];
    int bitpos = 0;
    int sck_rises = 0;
    int mosi_bad = 0;
    logic prev_sck = 1'b0, prev_mosi = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_burst_engine u_spi_burst_engine (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(miso_r), .spi_cs_n(spi_cs_n)
    );

    // mode 0 slave model
    always @(negedge spi_cs_n) begin
        bitpos = 0;
        miso_r = resp_b[0][7];
    end
    always @(posedge spi_sck) begin
        sck_rises++;
        if (bitpos < 512) cap_b[bitpos/8][7-(bitpos%8)] = spi_mosi;
        bitpos++;
    end
    always @(negedge spi_sck) begin
        if (!spi_cs_n && bitpos < 512) miso_r = resp_b[bitpos/8][7-(bitpos%8)];
    end

    // R7: MOSI must not move while SCK is high
    always @(negedge clk) begin
        if (rst_n && spi_sck && prev_sck && (spi_mosi !== prev_mosi)) mosi_bad++;
        prev_sck  = spi_sck;
        prev_mosi = spi_mosi;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 7'(a); reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 7'(a);
        #1 d = reg_rdata;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 64; i++) begin
            tx_b[i]   = 8'(seed*7 + i*13 + 5);
            resp_b[i] = 8'((seed*3) ^ (i*29 + 3));
        end
    endtask

    task automatic load_buf(input int n);
        for (int w = 0; w < (n+3)/4; w++)
            bus_write(32'h40 + 4*w, {tx_b[4*w+3], tx_b[4*w+2], tx_b[4*w+1], tx_b[4*w]});
    endtask

    task automatic launch(input int n, input bit dup, input bit hold);
        bus_write(32'h1C, {31'b0, dup});
        bus_write(32'h2C, {1'b0, hold, 30'b0});
        bus_write(32'h20, 32'(8*n - 1) << 17);
        bus_write(32'h30, 32'h0);
        sck_rises = 0;
        bus_write(32'h00, 32'h1 << 18);
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int k = 0; k < 8000; k++) begin
            bus_read(32'h30, v);
            if (v[4]) break;
        end
    endtask

    // compare buffer and captured MOSI against expectations
    task automatic check_burst(input int n, input bit dup, input int off, input string req_tx,
                               input string req_rx);
        logic [31:0] w;
        logic [7:0] a_tx, e_tx, a_rx, e_rx;
        bit bad_tx, bad_rx;
        bad_tx = 0; bad_rx = 0;
        a_tx = 0; e_tx = 0; a_rx = 0; e_rx = 0;
        for (int i = 0; i < n; i++) begin
            if (!bad_tx && cap_b[off+i] !== tx_b[i]) begin
                bad_tx = 1; a_tx = cap_b[off+i]; e_tx = tx_b[i];
            end
            bus_read(32'h40 + 4*(i/4), w);
            if (!bad_rx && w[8*(i%4) +: 8] !== (dup ? resp_b[off+i] : tx_b[i])) begin
                bad_rx = 1; a_rx = w[8*(i%4) +: 8]; e_rx = dup ? resp_b[off+i] : tx_b[i];
            end
        end
        chk(req_tx, {24'b0, a_tx}, {24'b0, e_tx});
        chk(req_rx, {24'b0, a_rx}, {24'b0, e_rx});
    endtask

    localparam int NV = 6;
    localparam int V_LEN [NV] = '{1, 4, 7, 64, 13, 2};
    localparam bit V_DUP [NV] = '{1, 1, 0, 1, 0, 1};

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
        chk("R1 sck", {31'b0, spi_sck}, 32'h0);
        bus_read(32'h00, v); chk("R1 start bit", {31'b0, v[18]}, 32'h0);
        bus_read(32'h30, v); chk("R1 done", {31'b0, v[4]}, 32'h0);

        // table-driven bursts: R3 R4 R5 R6
        for (int t = 0; t < NV; t++) begin
            fill(t + 1);
            load_buf(V_LEN[t]);
            launch(V_LEN[t], V_DUP[t], 1'b0);
            wait_done();
            chk("R3 sck pulses", 32'(sck_rises), 32'(8*V_LEN[t]));
            check_burst(V_LEN[t], V_DUP[t], 0, "R3 mosi byte", "R4 buffer byte");
            bus_read(32'h00, v); chk("R5 start self-clear", {31'b0, v[18]}, 32'h0);
            bus_read(32'h30, v); chk("R5 done set", {31'b0, v[4]}, 32'h1);
            chk("R6 cs released", {31'b0, spi_cs_n}, 32'h1);
            bus_write(32'h30, 32'h0);
            bus_read(32'h30, v); chk("R5 done cleared", {31'b0, v[4]}, 32'h0);
        end

        // R2 start visible one cycle later
        fill(20); load_buf(2);
        launch(2, 1'b1, 1'b0);
        bus_read(32'h00, v);
        chk("R2 start bit busy", {31'b0, v[18]}, 32'h1);
        chk("R2 cs asserted", {31'b0, spi_cs_n}, 32'h0);
        wait_done();

        // R8 start while busy is ignored
        fill(30); load_buf(8);
        launch(8, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        bus_write(32'h00, 32'h1 << 18);
        wait_done();
        repeat (10) @(negedge clk);
        chk("R8 pulses unchanged", 32'(sck_rises), 32'd64);
        check_burst(8, 1'b1, 0, "R8 mosi byte", "R8 buffer byte");

        // R6 hold across two bursts
        fill(40); load_buf(4);
        launch(4, 1'b1, 1'b1);
        wait_done();
        chk("R6 cs held", {31'b0, spi_cs_n}, 32'h0);
        check_burst(4, 1'b1, 0, "R6 first mosi", "R6 first buffer");
        for (int i = 0; i < 4; i++) tx_b[i] = 8'(8'hA0 + i);
        load_buf(4);
        launch(4, 1'b1, 1'b0);
        wait_done();
        check_burst(4, 1'b1, 4, "R6 second mosi", "R6 second buffer");
        chk("R6 cs released after last", {31'b0, spi_cs_n}, 32'h1);

        // R9 soft reset mid-burst
        fill(50); load_buf(16);
        launch(16, 1'b1, 1'b0);
        repeat (50) @(negedge clk);
        bus_write(32'h30, 32'h1 << 31);
        chk("R9 cs released", {31'b0, spi_cs_n}, 32'h1);
        chk("R9 sck low", {31'b0, spi_sck}, 32'h0);
        snap = sck_rises;
        repeat (20) @(negedge clk);
        chk("R9 sck stopped", 32'(sck_rises), 32'(snap));
        bus_read(32'h00, v); chk("R9 start bit", {31'b0, v[18]}, 32'h0);
        bus_read(32'h30, v); chk("R9 done", {31'b0, v[4]}, 32'h0);

        // R10 non-master mode blocks start
        bus_write(32'h30, 32'h1 << 30);
        sck_rises = 0;
        bus_write(32'h00, 32'h1 << 18);
        bus_read(32'h00, v); chk("R10 start ignored", {31'b0, v[18]}, 32'h0);
        repeat (20) @(negedge clk);
        chk("R10 cs idle", {31'b0, spi_cs_n}, 32'h1);
        chk("R10 no pulses", 32'(sck_rises), 32'd0);
        bus_write(32'h30, 32'h0);

        // R7 mode 0 pin behaviour over the whole run
        chk("R7 mosi stable while sck high", 32'(mosi_bad), 32'd0);
        chk("R7 sck idle low", {31'b0, spi_sck}, 32'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule